// File: doc/BRIEF.md
# Redundant-Enable UART Control Registers

This block holds the control and status registers that gate a host-facing UART. The control register carries a transmit-delay mode bit, a CRC-enable bit and an enable that is stored twice for safety. Two register ports can reach it: an SPI register port and a UART-service register port. Each port has an address, a write strobe, write data and a combinational read-data output. The service port can only reach the delay and CRC bits. The enable pair can only be changed over SPI.

The enable pair is checked every cycle. The UART counts as switched off only when both copies are zero. A pair with exactly one copy set is treated as on, and the block rewrites it to both ones in the next cycle that has no SPI control write. From the stored bits and two mode inputs the block derives three outputs: the UART enable, the effective CRC enable and the constant-delay select. It also keeps a read-only status bit that shows whether the UART is running. There is a hard reset and a separate soft reset, and they treat the status register differently.

Top module: `uart_ctl_regs`

## Requirements
- R1: While hard reset (`rst_n` low) is applied, the control register reads 0x03 and the status register reads 0x00 on both read ports.
- R2: Control register fields are: bit 4 constant-delay select, bit 3 CRC enable, bit 1 enable copy B, bit 0 enable copy A. Bits 7:5 and bit 2 always read 0, so an SPI write of 0xFF reads back as 0x1B.
- R3: `uart_enable` is 0 when both enable copies are 0 or when `monitor_mode` is 1. Otherwise it is 1, which includes a pair with only one copy set. It follows the stored pair in the same cycle that the pair changes.
- R4: If the stored enable copies differ and no SPI control write happens in that cycle, both copies read as 1 one cycle later. A pair of 00 or 11 is never changed by the repair logic.
- R5: A service-port write to the control address updates bits 4 and 3 only. Enable bits 1:0 keep their stored value whatever the written data.
- R6: When both ports write the control address in the same cycle, the SPI write is applied and the service write is dropped.
- R7: `crc_active` equals control bit 3, forced to 0 while `monitor_mode` is 1 or `baud_9k6` is 1.
- R8: `txdel_const` equals control bit 4.
- R9: Status bit 0 is a register. One cycle after any cycle with no reset, it holds 1 if the enable pair was nonzero and `monitor_mode` was 0, and 0 otherwise. Status bits 7:1 read 0.
- R10: A soft reset (`soft_rst_n` low, `rst_n` high) loads the control register with 0x03 and leaves the status register unchanged for that cycle.
- R11: Writes to the status address (1 by default) or to any address other than the control address (0 by default) change no register. Read data at unused addresses is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low |
| spi_addr | input | ADDR_W | SPI port register address |
| spi_we | input | 1 | SPI port write strobe |
| spi_wdata | input | 8 | SPI port write data |
| spi_rdata | output | 8 | SPI port read data for `spi_addr` |
| svc_addr | input | ADDR_W | Service port register address |
| svc_we | input | 1 | Service port write strobe |
| svc_wdata | input | 8 | Service port write data |
| svc_rdata | output | 8 | Service port read data for `svc_addr` |
| monitor_mode | input | 1 | Bus-monitor/analog mode is active |
| baud_9k6 | input | 1 | UART baud select is 9.6 kBd |
| uart_enable | output | 1 | UART interface is switched on |
| crc_active | output | 1 | Effective CRC enable |
| txdel_const | output | 1 | Constant transmission delay select |

## Verification
The bench writes each single-copy enable pattern, 01 and 10. It checks that the half-set value reads back for exactly one cycle and then becomes 11, and that `uart_enable` stays high throughout. A design that repairs in the write cycle, or does not repair at all, shows the wrong readback. A design that treats a half-set pair as off drops the enable. Service writes with zeroed enable bits are made against an on pair and against an off pair. A masking error then either switches the UART off or brings it back. A same-cycle collision shows whether SPI priority holds. A soft reset made while `monitor_mode` rises separates a status bit that holds from one that recomputes during soft reset. Writes to the status address must leave the control value unchanged.

// File: rtl/ucr_pkg.sv
// Package: shared field positions, masks and the control-register type for
// the redundant-enable UART control block. Assumes an 8-bit register width.
package ucr_pkg;

    localparam int DATA_W = 8;

    // Bit positions that the read and write paths depend on.
    localparam int POS_ENA  = 0;
    localparam int POS_ENB  = 1;
    localparam int POS_CRC  = 3;
    localparam int POS_TDEL = 4;

    // Decoded control register contents.
    typedef struct packed {
        logic       tdel;
        logic       crc;
        logic [1:0] en;   // en[1] = copy B, en[0] = copy A
    } ctrl_t;

    localparam ctrl_t CTRL_HARD_VAL = '{tdel: 1'b0, crc: 1'b0, en: 2'b11};
    localparam ctrl_t CTRL_SOFT_VAL = '{tdel: 1'b0, crc: 1'b0, en: 2'b11};

    // Place the control fields at their register positions; unused bits are 0.
    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[POS_ENA]  = c.en[0];
        w[POS_ENB]  = c.en[1];
        w[POS_CRC]  = c.crc;
        w[POS_TDEL] = c.tdel;
        return w;
    endfunction

    // Pull the control fields out of a written data word.
    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en[0] = w[POS_ENA];
        c.en[1] = w[POS_ENB];
        c.crc   = w[POS_CRC];
        c.tdel  = w[POS_TDEL];
        return c;
    endfunction

endpackage

// File: rtl/ucr_wr_select.sv
// Write arbiter: decodes each port's address and strobe, gives SPI priority
// over the service port, and reports whether the enable pair may be changed.
// Assumes writes to any address other than CTRL_ADDR are simply dropped.
module ucr_wr_select
    import ucr_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              spi_we,
    input  logic [ADDR_W-1:0] spi_addr,
    input  logic [DATA_W-1:0] spi_wdata,
    input  logic              svc_we,
    input  logic [ADDR_W-1:0] svc_addr,
    input  logic [DATA_W-1:0] svc_wdata,
    output logic              wr_hit,
    output logic              wr_en_ok,
    output ctrl_t             wr_val
);

    logic spi_hit;
    logic svc_hit;

    // Address decode for each port.
    always_comb begin
        spi_hit = spi_we && (spi_addr == CTRL_ADDR);
        svc_hit = svc_we && (svc_addr == CTRL_ADDR);
    end

    // Select the winning write; only SPI may touch the enable pair.
    always_comb begin
        wr_hit   = spi_hit || svc_hit;
        wr_en_ok = spi_hit;
        if (spi_hit) begin
            wr_val = word_to_ctrl(spi_wdata);
        end else begin
            wr_val = word_to_ctrl(svc_wdata);
        end
    end

endmodule

// File: rtl/ucr_ctrl_next.sv
// Next-state logic for the control register: applies the selected write with
// its field mask and repairs a half-set enable pair when SPI is not writing it.
// Assumes the caller handles the hard and soft reset priority.
module ucr_ctrl_next
    import ucr_pkg::*;
(
    input  ctrl_t cur,
    input  logic  wr_hit,
    input  logic  wr_en_ok,
    input  ctrl_t wr_val,
    output ctrl_t nxt,
    output logic  repairing
);

    logic pair_split;

    // Detect a pair whose copies disagree.
    always_comb begin
        pair_split = cur.en[1] ^ cur.en[0];
    end

    // Merge write data, masking, and redundancy repair.
    always_comb begin
        nxt       = cur;
        repairing = 1'b0;
        if (wr_hit) begin
            nxt.tdel = wr_val.tdel;
            nxt.crc  = wr_val.crc;
        end
        if (wr_en_ok) begin
            nxt.en = wr_val.en;
        end else if (pair_split) begin
            nxt.en    = 2'b11;
            repairing = 1'b1;
        end
    end

endmodule

// File: rtl/ucr_status_gen.sv
// Derived outputs: UART on indication, effective CRC enable and delay select.
// Assumes monitor_mode covers both bus-monitor and analog operation.
module ucr_status_gen
    import ucr_pkg::*;
(
    input  ctrl_t cur,
    input  logic  monitor_mode,
    input  logic  baud_9k6,
    output logic  uart_on,
    output logic  crc_eff,
    output logic  tdel_eff
);

    // Enable is off only for a fully cleared pair or in monitor mode.
    always_comb begin
        uart_on  = (|cur.en) && !monitor_mode;
        crc_eff  = cur.crc && !monitor_mode && !baud_9k6;
        tdel_eff = cur.tdel;
    end

endmodule

// File: rtl/ucr_read_mux.sv
// Read data selector for one register port: control word, status word or 0.
// Assumes combinational read with no side effects.
module ucr_read_mux
    import ucr_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             cur,
    input  logic              stat_on,
    output logic [DATA_W-1:0] rdata
);

    // Address-based selection of the register image.
    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            rdata = ctrl_to_word(cur);
        end else if (addr == STAT_ADDR) begin
            rdata[0] = stat_on;
        end
    end

endmodule

// File: rtl/uart_ctl_regs.sv
// Top: UART control and status registers with a duplicated enable bit.
// Holds the control register (hard/soft reset), the status register (hard
// reset only), and drives the enable, CRC and delay outputs. Assumes both
// resets are synchronous and active low, with hard reset taking priority.
module uart_ctl_regs
    import ucr_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_n,
    input  logic [ADDR_W-1:0] spi_addr,
    input  logic              spi_we,
    input  logic [7:0]        spi_wdata,
    output logic [7:0]        spi_rdata,
    input  logic [ADDR_W-1:0] svc_addr,
    input  logic              svc_we,
    input  logic [7:0]        svc_wdata,
    output logic [7:0]        svc_rdata,
    input  logic              monitor_mode,
    input  logic              baud_9k6,
    output logic              uart_enable,
    output logic              crc_active,
    output logic              txdel_const
);

    localparam int NPORT = 2;

    ctrl_t ctrl_q;
    ctrl_t ctrl_nxt;
    logic  stat_q;
    logic  wr_hit;
    logic  wr_en_ok;
    ctrl_t wr_val;
    logic  repairing;
    logic  uart_on;

    logic [ADDR_W-1:0] rd_addr [NPORT];
    logic [DATA_W-1:0] rd_data [NPORT];

    ucr_wr_select #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_wr_select (
        .spi_we    (spi_we),
        .spi_addr  (spi_addr),
        .spi_wdata (spi_wdata),
        .svc_we    (svc_we),
        .svc_addr  (svc_addr),
        .svc_wdata (svc_wdata),
        .wr_hit    (wr_hit),
        .wr_en_ok  (wr_en_ok),
        .wr_val    (wr_val)
    );

    ucr_ctrl_next u_ctrl_next (
        .cur       (ctrl_q),
        .wr_hit    (wr_hit),
        .wr_en_ok  (wr_en_ok),
        .wr_val    (wr_val),
        .nxt       (ctrl_nxt),
        .repairing (repairing)
    );

    ucr_status_gen u_status_gen (
        .cur          (ctrl_q),
        .monitor_mode (monitor_mode),
        .baud_9k6     (baud_9k6),
        .uart_on      (uart_on),
        .crc_eff      (crc_active),
        .tdel_eff     (txdel_const)
    );

    // Control register: hard reset, then soft reset, then normal update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_HARD_VAL;
        end else if (!soft_rst_n) begin
            ctrl_q <= CTRL_SOFT_VAL;
        end else begin
            ctrl_q <= ctrl_nxt;
        end
    end

    // Status register: cleared by hard reset, frozen during soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (soft_rst_n) begin
            stat_q <= uart_on;
        end
    end

    // Live enable output follows the stored pair.
    always_comb begin
        uart_enable = uart_on;
    end

    // Gather the port addresses for the replicated read selectors.
    always_comb begin
        rd_addr[0] = spi_addr;
        rd_addr[1] = svc_addr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        ucr_read_mux #(
            .ADDR_W    (ADDR_W),
            .CTRL_ADDR (CTRL_ADDR),
            .STAT_ADDR (STAT_ADDR)
        ) u_rd (
            .addr    (rd_addr[p]),
            .cur     (ctrl_q),
            .stat_on (stat_q),
            .rdata   (rd_data[p])
        );
    end

    // Drive the per-port read data outputs.
    always_comb begin
        spi_rdata = rd_data[0];
        svc_rdata = rd_data[1];
    end

endmodule

// File: rtl/ucr_checker.sv
// Checker: temporal properties for uart_ctl_regs, attached with bind below.
// Assumes it observes the stored control and status registers directly.
module ucr_checker
    import ucr_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst_n,
    input logic [ADDR_W-1:0] spi_addr,
    input logic              spi_we,
    input logic [7:0]        spi_wdata,
    input logic [ADDR_W-1:0] svc_addr,
    input logic              svc_we,
    input logic              monitor_mode,
    input logic              baud_9k6,
    input logic              uart_enable,
    input logic              crc_active,
    input logic              txdel_const,
    input ctrl_t             ctrl_q,
    input logic              stat_q
);

    logic spi_ctrl_wr;
    always_comb spi_ctrl_wr = spi_we && (spi_addr == CTRL_ADDR);

    assert_off_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en == 2'b00) |-> !uart_enable);

    assert_half_pair_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q.en[1] ^ ctrl_q.en[0]) && !monitor_mode) |-> uart_enable);

    assert_repair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_n && (ctrl_q.en[1] ^ ctrl_q.en[0]) && !spi_ctrl_wr)
        |=> (ctrl_q.en == 2'b11));

    assert_svc_keeps_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_n && !spi_ctrl_wr && (ctrl_q.en[1] == ctrl_q.en[0]))
        |=> $stable(ctrl_q.en));

    assert_spi_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_n && spi_ctrl_wr && svc_we && (svc_addr == CTRL_ADDR))
        |=> (ctrl_q.crc == $past(spi_wdata[POS_CRC])));

    assert_crc_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        crc_active |-> (!monitor_mode && !baud_9k6 && ctrl_q.crc));

    assert_monitor_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_n && monitor_mode) |=> !stat_q);

    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n |=> ((ctrl_q == CTRL_SOFT_VAL) && $stable(stat_q)));

endmodule

bind uart_ctl_regs ucr_checker #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) u_ucr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_n   (soft_rst_n),
    .spi_addr     (spi_addr),
    .spi_we       (spi_we),
    .spi_wdata    (spi_wdata),
    .svc_addr     (svc_addr),
    .svc_we       (svc_we),
    .monitor_mode (monitor_mode),
    .baud_9k6     (baud_9k6),
    .uart_enable  (uart_enable),
    .crc_active   (crc_active),
    .txdel_const  (txdel_const),
    .ctrl_q       (ctrl_q),
    .stat_q       (stat_q)
);

// File: tb/uart_ctl_regs_test.sv
// Directed bench for uart_ctl_regs: one task per scenario, each self-checking.
module uart_ctl_regs_test;

    localparam int          AW   = 4;
    localparam logic [3:0]  A_CTRL = 4'h0;
    localparam logic [3:0]  A_STAT = 4'h1;
    localparam logic [3:0]  A_NONE = 4'h7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst_n = 1'b1;
    logic [3:0] spi_addr = A_CTRL;
    logic       spi_we = 1'b0;
    logic [7:0] spi_wdata = 8'h00;
    logic [7:0] spi_rdata;
    logic [3:0] svc_addr = A_CTRL;
    logic       svc_we = 1'b0;
    logic [7:0] svc_wdata = 8'h00;
    logic [7:0] svc_rdata;
    logic       monitor_mode = 1'b0;
    logic       baud_9k6 = 1'b0;
    logic       uart_enable;
    logic       crc_active;
    logic       txdel_const;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    uart_ctl_regs #(.ADDR_W(AW), .CTRL_ADDR(A_CTRL), .STAT_ADDR(A_STAT)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
        .spi_addr(spi_addr), .spi_we(spi_we), .spi_wdata(spi_wdata), .spi_rdata(spi_rdata),
        .svc_addr(svc_addr), .svc_we(svc_we), .svc_wdata(svc_wdata), .svc_rdata(svc_rdata),
        .monitor_mode(monitor_mode), .baud_9k6(baud_9k6),
        .uart_enable(uart_enable), .crc_active(crc_active), .txdel_const(txdel_const)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Advance one clock and settle at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_spi(input logic [3:0] a, output logic [7:0] d);
        spi_addr = a;
        #1;
        d = spi_rdata;
    endtask

    task automatic spi_write(input logic [3:0] a, input logic [7:0] d);
        spi_addr = a; spi_wdata = d; spi_we = 1'b1;
        tick();
        spi_we = 1'b0;
    endtask

    task automatic svc_write(input logic [7:0] d);
        svc_addr = A_CTRL; svc_wdata = d; svc_we = 1'b1;
        tick();
        svc_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst_n = 1'b0;
        repeat (3) tick();
        rd_spi(A_CTRL, d); check("R1 ctrl in reset", d, 8'h03);
        rd_spi(A_STAT, d); check("R1 status in reset", d, 8'h00);
        svc_addr = A_CTRL; #1; check("R1 svc ctrl in reset", svc_rdata, 8'h03);
        rst_n = 1'b1;
        tick();
        rd_spi(A_STAT, d); check("R9 status after reset", d, 8'h01);
        check("R3 enable after reset", {7'd0, uart_enable}, 8'h01);
    endtask

    task automatic t_layout();
        logic [7:0] d;
        spi_write(A_CTRL, 8'hFF);
        rd_spi(A_CTRL, d); check("R2 unused bits zero", d, 8'h1B);
        check("R8 txdel set", {7'd0, txdel_const}, 8'h01);
        check("R7 crc on", {7'd0, crc_active}, 8'h01);
        spi_write(A_CTRL, 8'h0B);
        check("R8 txdel clear", {7'd0, txdel_const}, 8'h00);
        check("R7 crc still on", {7'd0, crc_active}, 8'h01);
    endtask

    task automatic t_crc_gate();
        logic [7:0] d;
        baud_9k6 = 1'b1; #1;
        check("R7 crc off at 9.6k", {7'd0, crc_active}, 8'h00);
        baud_9k6 = 1'b0; monitor_mode = 1'b1; #1;
        check("R7 crc off in monitor", {7'd0, crc_active}, 8'h00);
        check("R3 enable off in monitor", {7'd0, uart_enable}, 8'h00);
        tick();
        rd_spi(A_STAT, d); check("R9 status off in monitor", d, 8'h00);
        monitor_mode = 1'b0;
        tick();
        rd_spi(A_STAT, d); check("R9 status back on", d, 8'h01);
        check("R7 crc back on", {7'd0, crc_active}, 8'h01);
    endtask

    task automatic t_off();
        logic [7:0] d;
        spi_write(A_CTRL, 8'h00);
        check("R3 enable off for 00", {7'd0, uart_enable}, 8'h00);
        rd_spi(A_STAT, d); check("R9 status lags one cycle", d, 8'h01);
        tick();
        rd_spi(A_STAT, d); check("R9 status off", d, 8'h00);
        rd_spi(A_CTRL, d); check("R4 00 pair not repaired", d, 8'h00);
    endtask

    task automatic t_repair(input logic [7:0] pat);
        logic [7:0] d;
        spi_write(A_CTRL, pat);
        rd_spi(A_CTRL, d); check("R4 half pair visible one cycle", d, pat);
        check("R3 half pair is on", {7'd0, uart_enable}, 8'h01);
        tick();
        rd_spi(A_CTRL, d); check("R4 pair repaired", d, 8'h03);
        check("R3 enable stays on", {7'd0, uart_enable}, 8'h01);
    endtask

    task automatic t_svc_mask();
        logic [7:0] d;
        spi_write(A_CTRL, 8'h03);
        svc_write(8'h18);
        rd_spi(A_CTRL, d); check("R5 svc sets txdel/crc only", d, 8'h1B);
        svc_write(8'h00);
        rd_spi(A_CTRL, d); check("R5 svc cannot clear pair", d, 8'h03);
        check("R5 enable kept", {7'd0, uart_enable}, 8'h01);
        spi_write(A_CTRL, 8'h00);
        svc_write(8'h03);
        rd_spi(A_CTRL, d); check("R5 svc cannot set pair", d, 8'h00);
        check("R5 enable stays off", {7'd0, uart_enable}, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        spi_write(A_CTRL, 8'h03);
        spi_addr = A_CTRL; spi_wdata = 8'h00; spi_we = 1'b1;
        svc_addr = A_CTRL; svc_wdata = 8'h18; svc_we = 1'b1;
        tick();
        spi_we = 1'b0; svc_we = 1'b0;
        rd_spi(A_CTRL, d); check("R6 spi wins collision", d, 8'h00);
    endtask

    task automatic t_bad_addr();
        logic [7:0] d;
        spi_write(A_CTRL, 8'h03);
        tick();
        spi_write(A_STAT, 8'h00);
        rd_spi(A_CTRL, d); check("R11 status write ignored ctrl", d, 8'h03);
        rd_spi(A_STAT, d); check("R11 status write ignored stat", d, 8'h01);
        spi_write(A_NONE, 8'h18);
        rd_spi(A_CTRL, d); check("R11 stray write ignored", d, 8'h03);
        rd_spi(A_NONE, d); check("R11 unused reads zero", d, 8'h00);
        svc_addr = A_STAT; svc_wdata = 8'h18; svc_we = 1'b1;
        tick();
        svc_we = 1'b0;
        rd_spi(A_CTRL, d); check("R11 svc status write ignored", d, 8'h03);
    endtask

    task automatic t_soft();
        logic [7:0] d;
        spi_write(A_CTRL, 8'h18);
        spi_write(A_CTRL, 8'h1B);
        tick();
        rd_spi(A_STAT, d); check("R9 status on before soft", d, 8'h01);
        soft_rst_n = 1'b0; monitor_mode = 1'b1;
        tick();
        soft_rst_n = 1'b1;
        rd_spi(A_CTRL, d); check("R10 soft reset value", d, 8'h03);
        rd_spi(A_STAT, d); check("R10 status held in soft reset", d, 8'h01);
        tick();
        rd_spi(A_STAT, d); check("R9 status follows after soft", d, 8'h00);
        monitor_mode = 1'b0;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_layout();
        t_crc_gate();
        t_off();
        t_repair(8'h01);
        t_repair(8'h02);
        t_svc_mask();
        t_priority();
        t_bad_addr();
        t_soft();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule